// File: doc/BRIEF.md
# Bidirectional Flush-Before-Read Ordering Controller

This block keeps reads behind earlier posted writes in a bridge between a processor bus and a PCI bus. Each direction owns a posted-write FIFO, seen here only as an occupancy count. A read starting on either bus must not overtake writes that are still buffered. Two mechanisms enforce this. Against its own outbound FIFO, the reading side is held with wait states until that FIFO drains. Against writes travelling the other way, a pending-write flag on the opposite side forces an immediate retry.

The bus engines report a transaction start together with a read/write qualifier. The block waits a fixed decode latency, then decides once: retry, hold or pass. Each direction has its own enable. With an enable clear, reads on that side pass untouched. The FIFO datapaths, address decode and bus protocols live outside this block. All pins are plain control levels and pulses. There is no streaming data, so there is no valid/ready back-pressure.

Top module: `fbr_order_ctl`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, all four outputs are 0 and both pending-write flags are clear.
- R2: A processor read with `cpu_flush_en`=1, no PCI-side pending write, and `to_pci_cnt`≠0 at decision time raises `cpu_hold`. The hold stays high until `to_pci_cnt`=0 has been sampled.
- R3: A PCI read with `pci_flush_en`=1, no processor-side pending write, and `to_cpu_cnt`≠0 at decision time raises `pci_hold`. The hold stays high until `to_cpu_cnt`=0 has been sampled.
- R4: `cpu_wr_commit` sets the processor-side pending flag. The flag clears on an edge where `to_pci_cnt`=0 and no commit is present. If a commit and a zero count arrive in the same cycle, the set wins.
- R5: `pci_wr_accept` sets the PCI-side pending flag, and `pci_wr_done` clears it. If both arrive in the same cycle, the set wins.
- R6: A PCI read with `pci_flush_en`=1 that finds the processor-side flag set at decision time gets a one-cycle `pci_retry` pulse.
- R7: A processor read with `cpu_flush_en`=1 that finds the PCI-side flag set at decision time gets a one-cycle `cpu_retry` pulse.
- R8: The decision is taken at the clock edge exactly `DEC_LAT` edges after the edge that sampled the start strobe. Its result appears on the outputs right after that edge, and never earlier.
- R9: Transactions whose qualifier marks them as writes (`*_is_read`=0) are never held or retried.
- R10: When a side's enable is 0 at decision time, its read passes, with no hold and no retry.
- R11: When both retry and hold conditions hold at one decision, only the retry pulse is produced and no hold is raised.
- R12: An active hold drops on the edge after the relevant FIFO count is sampled as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_flush_en | input | 1 | Enables ordering for reads that start on the processor bus |
| pci_flush_en | input | 1 | Enables ordering for reads that start on the PCI bus |
| cpu_start | input | 1 | One-cycle processor transaction start |
| cpu_is_read | input | 1 | Qualifier for `cpu_start`: 1 = read, 0 = write |
| cpu_wr_commit | input | 1 | Processor slave committed to a posted write |
| pci_start | input | 1 | One-cycle PCI transaction start |
| pci_is_read | input | 1 | Qualifier for `pci_start`: 1 = read, 0 = write |
| pci_wr_accept | input | 1 | PCI slave accepted a posted write |
| pci_wr_done | input | 1 | That posted write completed on the processor bus |
| to_pci_cnt | input | CNT_W | Occupancy of the processor-to-PCI FIFO |
| to_cpu_cnt | input | CNT_W | Occupancy of the PCI-to-processor FIFO |
| cpu_hold | output | 1 | Wait-state hold toward the processor |
| cpu_retry | output | 1 | One-cycle retry toward the processor |
| pci_hold | output | 1 | Wait-state hold toward the PCI master |
| pci_retry | output | 1 | One-cycle retry toward the PCI master |

## Verification
A retry and a hold can be due at the same decision edge. This happens when the opposite side has a pending write and the own-side FIFO is not empty. The bench sets up exactly that state: it commits a processor write while `to_cpu_cnt` is non-zero, then starts a PCI read. It expects a single `pci_retry` pulse with `pci_hold` staying low. A behavioural model tracks decision edges by absolute edge number. Every clock, the model compares all four outputs against the design, so a hold that leaks out next to the retry is caught in the same cycle.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  // Response of one side's decision logic.
  typedef struct packed {
    logic hold;
    logic retry;
  } fbr_resp_t;
endpackage

// File: rtl/fbr_pend_flag.sv
module fbr_pend_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // Registered set/clear bit; a set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/fbr_side_ctl.sv
module fbr_side_ctl
  import fbr_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int DEC_LAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             is_read_i,
  input  logic             opp_pend_i,
  input  logic [CNT_W-1:0] own_cnt_i,
  output fbr_resp_t        resp_o
);
  localparam int TW = $clog2(DEC_LAT + 1);

  logic [TW-1:0] tmr_q;
  logic          rd_q;
  logic          fire;
  logic          want_retry;
  logic          want_hold;
  logic          own_empty;

  assign own_empty  = (own_cnt_i == '0);
  assign fire       = (tmr_q == TW'(1)) && rd_q && en_i;
  assign want_retry = fire && opp_pend_i;
  assign want_hold  = fire && !opp_pend_i && !own_empty;

  // Decode-latency timer, reloaded by every start strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q <= '0;
      rd_q  <= 1'b0;
    end else if (start_i) begin
      tmr_q <= TW'(DEC_LAT);
      rd_q  <= is_read_i;
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - TW'(1);
    end
  end

  // Retry is a pulse; hold is a level released once the FIFO is empty.
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_o <= '0;
    end else begin
      resp_o.retry <= want_retry;
      if (want_hold)      resp_o.hold <= 1'b1;
      else if (own_empty) resp_o.hold <= 1'b0;
    end
  end
endmodule

// File: rtl/fbr_order_ctl.sv
module fbr_order_ctl
  import fbr_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int DEC_LAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_flush_en,
  input  logic             pci_flush_en,
  input  logic             cpu_start,
  input  logic             cpu_is_read,
  input  logic             cpu_wr_commit,
  input  logic             pci_start,
  input  logic             pci_is_read,
  input  logic             pci_wr_accept,
  input  logic             pci_wr_done,
  input  logic [CNT_W-1:0] to_pci_cnt,
  input  logic [CNT_W-1:0] to_cpu_cnt,
  output logic             cpu_hold,
  output logic             cpu_retry,
  output logic             pci_hold,
  output logic             pci_retry
);
  logic      cpu_pend;   // processor posted write not yet drained to PCI
  logic      pci_pend;   // PCI posted write not yet completed on processor bus
  fbr_resp_t cpu_resp;
  fbr_resp_t pci_resp;

  fbr_pend_flag u_cpu_pend (
    .clk    (clk),
    .rst    (rst),
    .set_i  (cpu_wr_commit),
    .clr_i  (to_pci_cnt == '0),
    .flag_o (cpu_pend)
  );

  fbr_pend_flag u_pci_pend (
    .clk    (clk),
    .rst    (rst),
    .set_i  (pci_wr_accept),
    .clr_i  (pci_wr_done),
    .flag_o (pci_pend)
  );

  fbr_side_ctl #(.CNT_W(CNT_W), .DEC_LAT(DEC_LAT)) u_cpu_side (
    .clk        (clk),
    .rst        (rst),
    .en_i       (cpu_flush_en),
    .start_i    (cpu_start),
    .is_read_i  (cpu_is_read),
    .opp_pend_i (pci_pend),
    .own_cnt_i  (to_pci_cnt),
    .resp_o     (cpu_resp)
  );

  fbr_side_ctl #(.CNT_W(CNT_W), .DEC_LAT(DEC_LAT)) u_pci_side (
    .clk        (clk),
    .rst        (rst),
    .en_i       (pci_flush_en),
    .start_i    (pci_start),
    .is_read_i  (pci_is_read),
    .opp_pend_i (cpu_pend),
    .own_cnt_i  (to_cpu_cnt),
    .resp_o     (pci_resp)
  );

  assign cpu_hold  = cpu_resp.hold;
  assign cpu_retry = cpu_resp.retry;
  assign pci_hold  = pci_resp.hold;
  assign pci_retry = pci_resp.retry;
endmodule

// File: rtl/fbr_order_chk.sv
module fbr_order_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_flush_en,
  input logic             pci_flush_en,
  input logic             cpu_wr_commit,
  input logic             pci_wr_accept,
  input logic [CNT_W-1:0] to_pci_cnt,
  input logic [CNT_W-1:0] to_cpu_cnt,
  input logic             cpu_pend,
  input logic             pci_pend,
  input logic             cpu_hold,
  input logic             cpu_retry,
  input logic             pci_hold,
  input logic             pci_retry
);
  AST_CPU_FLAG_SET: assert property (@(posedge clk) disable iff (rst) cpu_wr_commit |=> cpu_pend); // R4
  AST_PCI_FLAG_SET: assert property (@(posedge clk) disable iff (rst) pci_wr_accept |=> pci_pend); // R5
  AST_PCI_RETRY_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(pci_retry) |-> $past(cpu_pend)); // R6
  AST_CPU_RETRY_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(cpu_retry) |-> $past(pci_pend)); // R7
  AST_CPU_HOLD_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst) $rose(cpu_hold) |-> $past(to_pci_cnt != '0)); // R2
  AST_PCI_HOLD_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst) $rose(pci_hold) |-> $past(to_cpu_cnt != '0)); // R3
  AST_CPU_OFF_NO_RETRY: assert property (@(posedge clk) disable iff (rst) $rose(cpu_retry) |-> $past(cpu_flush_en)); // R10
  AST_PCI_OFF_NO_RETRY: assert property (@(posedge clk) disable iff (rst) $rose(pci_retry) |-> $past(pci_flush_en)); // R10
  AST_CPU_RETRY_BEATS_HOLD: assert property (@(posedge clk) disable iff (rst) cpu_retry |-> !$rose(cpu_hold)); // R11
  AST_PCI_RETRY_BEATS_HOLD: assert property (@(posedge clk) disable iff (rst) pci_retry |-> !$rose(pci_hold)); // R11
  AST_CPU_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst) (cpu_hold && to_pci_cnt == '0) |=> !cpu_hold); // R12
  AST_PCI_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst) (pci_hold && to_cpu_cnt == '0) |=> !pci_hold); // R12
endmodule

bind fbr_order_ctl fbr_order_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cpu_flush_en  (cpu_flush_en),
  .pci_flush_en  (pci_flush_en),
  .cpu_wr_commit (cpu_wr_commit),
  .pci_wr_accept (pci_wr_accept),
  .to_pci_cnt    (to_pci_cnt),
  .to_cpu_cnt    (to_cpu_cnt),
  .cpu_pend      (cpu_pend),
  .pci_pend      (pci_pend),
  .cpu_hold      (cpu_hold),
  .cpu_retry     (cpu_retry),
  .pci_hold      (pci_hold),
  .pci_retry     (pci_retry)
);

// File: tb/fbr_order_ctl_tb.sv
module fbr_order_ctl_tb;
  localparam int CNT_W   = 4;
  localparam int DEC_LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_flush_en = 1'b0, pci_flush_en = 1'b0;
  logic cpu_start = 1'b0, cpu_is_read = 1'b0, cpu_wr_commit = 1'b0;
  logic pci_start = 1'b0, pci_is_read = 1'b0, pci_wr_accept = 1'b0, pci_wr_done = 1'b0;
  logic [CNT_W-1:0] to_pci_cnt = '0, to_cpu_cnt = '0;
  logic cpu_hold, cpu_retry, pci_hold, pci_retry;

  always #2.5 clk = ~clk; // 200 MHz

  fbr_order_ctl #(.CNT_W(CNT_W), .DEC_LAT(DEC_LAT)) u_dut (
    .clk(clk), .rst(rst),
    .cpu_flush_en(cpu_flush_en), .pci_flush_en(pci_flush_en),
    .cpu_start(cpu_start), .cpu_is_read(cpu_is_read), .cpu_wr_commit(cpu_wr_commit),
    .pci_start(pci_start), .pci_is_read(pci_is_read),
    .pci_wr_accept(pci_wr_accept), .pci_wr_done(pci_wr_done),
    .to_pci_cnt(to_pci_cnt), .to_cpu_cnt(to_cpu_cnt),
    .cpu_hold(cpu_hold), .cpu_retry(cpu_retry),
    .pci_hold(pci_hold), .pci_retry(pci_retry)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1 reset";

  // Behavioural reference: decisions scheduled by absolute edge number.
  int edge_no = 0;
  int cpu_due = -1, pci_due = -1;
  bit cpu_rd = 0, pci_rd = 0;
  bit m_cpend = 0, m_ppend = 0;
  bit m_ch = 0, m_cr = 0, m_ph = 0, m_pr = 0;

  always @(posedge clk) begin
    bit nc, np;
    if (rst) begin
      cpu_due = -1; pci_due = -1; m_cpend = 0; m_ppend = 0;
      m_ch = 0; m_cr = 0; m_ph = 0; m_pr = 0;
    end else begin
      m_cr = 0; m_pr = 0;
      if (cpu_due == edge_no && cpu_rd && cpu_flush_en && m_ppend) m_cr = 1;
      else if (cpu_due == edge_no && cpu_rd && cpu_flush_en && to_pci_cnt != 0) m_ch = 1;
      else if (to_pci_cnt == 0) m_ch = 0;
      if (pci_due == edge_no && pci_rd && pci_flush_en && m_cpend) m_pr = 1;
      else if (pci_due == edge_no && pci_rd && pci_flush_en && to_cpu_cnt != 0) m_ph = 1;
      else if (to_cpu_cnt == 0) m_ph = 0;
      if (cpu_start) begin cpu_due = edge_no + DEC_LAT; cpu_rd = cpu_is_read; end
      if (pci_start) begin pci_due = edge_no + DEC_LAT; pci_rd = pci_is_read; end
      nc = cpu_wr_commit ? 1'b1 : (to_pci_cnt == 0 ? 1'b0 : m_cpend);
      np = pci_wr_accept ? 1'b1 : (pci_wr_done ? 1'b0 : m_ppend);
      m_cpend = nc; m_ppend = np;
    end
    edge_no++;
  end

  task automatic cmp(string name, logic got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b exp %0b at t=%0t", tag, name, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cmp("cpu_hold", cpu_hold, m_ch);
    cmp("cpu_retry", cpu_retry, m_cr);
    cmp("pci_hold", pci_hold, m_ph);
    cmp("pci_retry", pci_retry, m_pr);
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic clear_pulses();
    cpu_start = 0; pci_start = 0; cpu_wr_commit = 0;
    pci_wr_accept = 0; pci_wr_done = 0;
  endtask

  task automatic pulse_cpu(bit rd);
    cpu_start = 1; cpu_is_read = rd; step(1); clear_pulses();
  endtask

  task automatic pulse_pci(bit rd);
    pci_start = 1; pci_is_read = rd; step(1); clear_pulses();
  endtask

  initial begin
    step(3);
    tag = "R1 reset release";
    rst = 0;
    step(2);

    // R2 / R8 / R12: processor read waits for the PCI-bound FIFO.
    tag = "R2 R8 R12 cpu hold";
    cpu_flush_en = 1; pci_flush_en = 1; to_pci_cnt = 3;
    pulse_cpu(1); step(DEC_LAT + 2);
    to_pci_cnt = 1; step(2);
    to_pci_cnt = 0; step(3);

    // R3: PCI read waits for the processor-bound FIFO.
    tag = "R3 pci hold";
    to_cpu_cnt = 2;
    pulse_pci(1); step(DEC_LAT + 3);
    to_cpu_cnt = 0; step(3);

    // R6 / R4: processor posted write forces a PCI retry until the drain.
    tag = "R6 R4 pci retry";
    to_pci_cnt = 2; cpu_wr_commit = 1; step(1); clear_pulses();
    pulse_pci(1); step(DEC_LAT + 2);
    to_pci_cnt = 0; step(2);
    tag = "R4 flag cleared";
    pulse_pci(1); step(DEC_LAT + 2);

    // R4 set wins: commit lands while the count is zero, at a decision edge.
    tag = "R4 set wins";
    pulse_pci(1); step(DEC_LAT - 2);
    cpu_wr_commit = 1; step(1); clear_pulses();
    step(4);

    // R7 / R5: PCI posted write forces a processor retry.
    tag = "R7 R5 cpu retry";
    pci_wr_accept = 1; step(1); clear_pulses();
    pulse_cpu(1); step(DEC_LAT + 2);
    tag = "R5 set wins";
    pci_wr_accept = 1; pci_wr_done = 1; step(1); clear_pulses();
    pulse_cpu(1); step(DEC_LAT + 2);
    pci_wr_done = 1; step(1); clear_pulses();
    tag = "R5 flag cleared";
    to_pci_cnt = 0;
    pulse_cpu(1); step(DEC_LAT + 2);

    // R9: writes never held or retried.
    tag = "R9 writes pass";
    pci_wr_accept = 1; to_pci_cnt = 4; to_cpu_cnt = 4; step(1); clear_pulses();
    cpu_wr_commit = 1; step(1); clear_pulses();
    pulse_cpu(0); pulse_pci(0); step(DEC_LAT + 3);

    // R10: enables clear, reads pass.
    tag = "R10 disabled";
    cpu_flush_en = 0; pci_flush_en = 0;
    pulse_cpu(1); pulse_pci(1); step(DEC_LAT + 3);
    cpu_flush_en = 1; pci_flush_en = 1;

    // R11: retry and hold both due at one PCI decision.
    tag = "R11 retry over hold";
    to_pci_cnt = 4; to_cpu_cnt = 3; cpu_wr_commit = 1; step(1); clear_pulses();
    pulse_pci(1); step(DEC_LAT + 3);
    pci_wr_done = 1; to_pci_cnt = 0; to_cpu_cnt = 0; step(1); clear_pulses();
    step(3);

    // R1: reset in the middle of a hold.
    tag = "R1 mid reset";
    to_pci_cnt = 2; pulse_cpu(1); step(DEC_LAT + 1);
    rst = 1; step(2); rst = 0; to_pci_cnt = 0; step(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule